// File: doc/BRIEF.md
# Multi-Mode LFSR Entropy Conditioner

This block turns a stream of weak-entropy raw samples into conditioned bits at half the sample rate. The raw data never enters the shift path directly. Each 2-bit raw sample picks which feedback polynomial a 32-bit shift register applies on that step. A free-running 31-bit auxiliary register picks whether the feedback is taken in XOR or XNOR form. The state therefore hops between eight well-mixed maximal-length trajectories.

Two such stages are chained. Stage 1 steps once per accepted raw sample and yields one bit, the LSB of its new state. A decimator pairs consecutive stage-1 bits into the 2-bit selector for stage 2. Stage 2 steps once per pair, and the LSB of its state is the block's output. The block is placed between a raw entropy source and a downstream deterministic generator that takes the conditioned bits as seed material.

Top module: `lfsr_conditioner`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `cond_valid` is 0 and `cond_bit` equals bit 0 of the stage-2 seed.
- R2: Over any run, the number of `cond_valid` pulses equals the number of accepted raw samples divided by two, rounded down. Two pulses never appear in consecutive cycles.
- R3: `cond_valid` is 1 in exactly the cycle after every second accepted sample, counted from reset, and is 0 in all other cycles.
- R4: A cycle with `raw_valid` low changes no internal state. Idle gaps therefore leave the output sequence unchanged.
- R5: Each stage shifts its state left and inserts the feedback bit at bit 0. The feedback is the XOR of the tapped state bits. The 2-bit selector picks the taps (numbered from 0 = LSB): 0 → bits 31,21,1,0; 1 → bits 31,6,4,2,1,0; 2 → bits 31,27,26,0; 3 → bits 31,29,25,24. When the mode bit is 1 the feedback is inverted (XNOR form); when it is 0 the XOR form is used.
- R6: The auxiliary register is a 31-bit left shift register. Its feedback is bit 30 XOR bit 27, it resets to `AUX_SEED`, and it advances once per accepted sample. Its bit 0 is the stage-1 mode bit and its bit `AUX_SEL2` is the stage-2 mode bit, both taken before that cycle's advance.
- R7: If a step would leave either stage in the all-zero state, that stage loads 32'h1 instead.
- R8: The stage-2 selector is {second stage-1 bit, first stage-1 bit} of the pair. `cond_bit` is bit 0 of the stage-2 state after its step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_valid | input | 1 | Raw sample present this cycle |
| raw_bits | input | 2 | Raw sample, used as the stage-1 tap-set selector |
| cond_valid | output | 1 | Conditioned bit valid pulse |
| cond_bit | output | 1 | Conditioned output bit |

## Verification
Every cycle, the assertions check that both stages stay out of the all-zero state, that idle cycles leave all three registers untouched, and that the auxiliary register follows its recurrence. They also check that an output pulse only follows an accepted sample and is never repeated in the next cycle. Only the bench's scenarios can show that the output bits are the right ones. The bench compares each bit with an independent model of the eight transition functions, over sweeps of every selector code with and without idle gaps. It also runs a seed chosen so that the zero-state guard must act on the very first step.

// File: rtl/lfsr_conditioner.sv
module lfsr_conditioner #(
  parameter logic [31:0] S1_SEED  = 32'hC3A5_9E17,
  parameter logic [31:0] S2_SEED  = 32'h5F0E_D2B1,
  parameter logic [30:0] AUX_SEED = 31'h2BAD_F00D,
  parameter int          AUX_SEL2 = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw_valid,
  input  logic [1:0] raw_bits,
  output logic       cond_valid,
  output logic       cond_bit
);

  function automatic logic [31:0] advance(input logic [31:0] s, input logic [1:0] sel, input logic inv);
    logic        fb;
    logic [31:0] n;
    case (sel)
      2'd0:    fb = s[31] ^ s[21] ^ s[1] ^ s[0];
      2'd1:    fb = s[31] ^ s[6] ^ s[4] ^ s[2] ^ s[1] ^ s[0];
      2'd2:    fb = s[31] ^ s[27] ^ s[26] ^ s[0];
      default: fb = s[31] ^ s[29] ^ s[25] ^ s[24];
    endcase
    n = {s[30:0], fb ^ inv};
    if (n == 32'd0) n = 32'd1;
    return n;
  endfunction

  logic [30:0] aux;
  logic [31:0] s1, s2;
  logic        hold, have;

  wire [30:0] aux_next = {aux[29:0], aux[30] ^ aux[27]};
  wire [31:0] s1_next  = advance(s1, raw_bits, aux[0]);
  wire [31:0] s2_next  = advance(s2, {s1_next[0], hold}, aux[AUX_SEL2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux        <= AUX_SEED;
      s1         <= S1_SEED;
      s2         <= S2_SEED;
      hold       <= 1'b0;
      have       <= 1'b0;
      cond_valid <= 1'b0;
    end else begin
      cond_valid <= raw_valid & have;
      if (raw_valid) begin
        aux  <= aux_next;
        s1   <= s1_next;
        have <= ~have;
        if (have) s2 <= s2_next;
        else      hold <= s1_next[0];
      end
    end
  end

  assign cond_bit = s2[0];

endmodule

// File: rtl/lfsr_conditioner_chk.sv
module lfsr_conditioner_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        raw_valid,
  input logic        cond_valid,
  input logic [31:0] s1,
  input logic [31:0] s2,
  input logic [30:0] aux
);

  p_s1_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n) s1 != 32'd0);
  p_s2_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n) s2 != 32'd0);
  p_aux_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n) aux != 31'd0);
  p_aux_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    raw_valid |=> aux == {$past(aux[29:0]), $past(aux[30]) ^ $past(aux[27])});
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_valid |=> $stable(s1) && $stable(s2) && $stable(aux));
  p_valid_after_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cond_valid |-> $past(raw_valid));
  p_no_back_to_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cond_valid |=> !cond_valid);

endmodule

bind lfsr_conditioner lfsr_conditioner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .raw_valid(raw_valid), .cond_valid(cond_valid),
  .s1(s1), .s2(s2), .aux(aux)
);

// File: tb/lfsr_conditioner_test.sv
module lfsr_conditioner_test;
  localparam logic [31:0] T_S1  = 32'h8000_0000;
  localparam logic [31:0] T_S2  = 32'h5F0E_D2B1;
  localparam logic [30:0] T_AUX = 31'h2BAD_F00D;

  logic clk = 1'b0, rst_n = 1'b0, raw_valid = 1'b0;
  logic [1:0] raw_bits = 2'd0;
  logic cond_valid, cond_bit;

  int compared = 0, mismatched = 0, n_in = 0, n_out = 0;
  bit done = 0;

  logic [30:0] m_aux;
  logic [31:0] m_s1, m_s2;
  logic m_hold, m_have;

  always #10 clk = ~clk;

  lfsr_conditioner #(.S1_SEED(T_S1), .S2_SEED(T_S2), .AUX_SEED(T_AUX), .AUX_SEL2(15)) uut (
    .clk(clk), .rst_n(rst_n), .raw_valid(raw_valid), .raw_bits(raw_bits),
    .cond_valid(cond_valid), .cond_bit(cond_bit));

  function automatic logic [31:0] m_step(input logic [31:0] s, input logic [1:0] sel, input logic inv);
    logic [31:0] mask, n;
    mask = (sel == 2'd0) ? 32'h8020_0003 : (sel == 2'd1) ? 32'h8000_0057 :
           (sel == 2'd2) ? 32'h8C00_0001 : 32'hA300_0000;
    n = {s[30:0], (^(s & mask)) ^ inv};
    return (n == 32'd0) ? 32'd1 : n;
  endfunction

  task automatic check(input logic got, input logic exp, input string tag);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [1:0] r, input string tag);
    logic exp_v, exp_b;
    logic b1;
    raw_valid = v;
    raw_bits  = r;
    exp_v = 1'b0;
    exp_b = m_s2[0];
    if (v) begin
      n_in++;
      m_s1 = m_step(m_s1, r, m_aux[0]);
      b1 = m_s1[0];
      if (m_have) begin
        m_s2 = m_step(m_s2, {b1, m_hold}, m_aux[15]);
        exp_v = 1'b1;
        exp_b = m_s2[0];
      end else m_hold = b1;
      m_have = ~m_have;
      m_aux = {m_aux[29:0], m_aux[30] ^ m_aux[27]};
    end
    @(posedge clk);
    @(negedge clk);
    check(cond_valid, exp_v, {tag, " R3 valid"});
    if (cond_valid) n_out++;
    if (exp_v) check(cond_bit, exp_b, {tag, " R5/R6/R8 bit"});
    raw_valid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    m_aux = T_AUX; m_s1 = T_S1; m_s2 = T_S2; m_hold = 1'b0; m_have = 1'b0;
    repeat (3) @(negedge clk);
    check(cond_valid, 1'b0, "R1 valid in reset");
    check(cond_bit, T_S2[0], "R1 bit in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(cond_valid, 1'b0, "R1 valid after reset");
    // first step: seed 0x80000000 in XNOR form would reach zero, guard loads 1
    apply(1'b1, 2'd0, "R7 first");
    apply(1'b1, 2'd1, "R7 pair");
    for (int i = 0; i < 64; i++) apply(1'b1, 2'(i % 4), "sweep");
    for (int i = 0; i < 256; i++) begin
      if (i % 3 == 0) apply(1'b0, 2'(i % 4), "R4 gap");
      apply(1'b1, 2'((i * 7 + i / 5) % 4), "mix");
    end
    apply(1'b1, 2'd3, "odd");
    for (int i = 0; i < 8; i++) apply(1'b0, 2'(i % 4), "R4 idle");
    apply(1'b1, 2'd2, "R4 resume");
    for (int i = 0; i < 16; i++) begin
      apply(1'b1, 2'(i / 4), "R2 burst");
      apply(1'b0, 2'd0, "R2 spacer");
    end
    compared++;
    if (n_out != n_in / 2) begin
      mismatched++;
      $display("FAIL R2 outputs %0d expected %0d", n_out, n_in / 2);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule